// File: doc/BRIEF.md
# Ring-Oscillator Pool Pair Selector

This block performs the enrollment-time choice of an oscillator pair for a delay-based physical unclonable function. A pool of `POOL_SIZE` ring oscillators is measured elsewhere. Their frequency counts are streamed in over a valid/ready input, one count per accepted cycle, in oscillator index order. The block keeps the highest count (the fastest oscillator) and the lowest count (the slowest oscillator) seen so far. After the last count of the pool it reports both indices, the count difference between them, a response bit and a flag that says whether the pair is good enough to define a bit at all.

A wider frequency gap gives a bit that is more likely to survive changes in temperature, supply and ageing. The programmable threshold therefore acts as a reliability control. Pairs whose gap falls below it yield no bit. A pool in which every oscillator reads the same count also yields no bit. By default the fastest oscillator is listed first, so a defined bit reads 1. An order input lists the slowest first instead, and the stored bit then reads 0. This lets enrollment choose either polarity for the stored response.

Top module: `ro_pool_pick`

## Requirements
- R1: While `rst_n` is low, `res_valid_o` and `cnt_ready_o` are 0. From the first clock edge after reset is released, `cnt_ready_o` is 1.
- R2: `res_valid_o` is 1 for exactly the one cycle that follows the acceptance of the `POOL_SIZE`-th count of a pool. At all other times it is 0.
- R3: The fastest index is the index whose count is highest. When several counts share that value, the lowest such index is reported.
- R4: The slowest index is the index whose count is lowest. When several counts share that value, the lowest such index is reported.
- R5: `res_gap_o` equals the highest count minus the lowest count as an unsigned number at the full count width. This includes the extremes (all-ones minus zero).
- R6: When the two indices differ, `res_defined_o` is 1 exactly when the gap is greater than or equal to `thresh_i`. A gap equal to the threshold counts as defined.
- R7: When the fastest and slowest indices are the same (all counts equal), `res_defined_o` is 0 for every threshold, including zero.
- R8: With `swap_i`=0, `res_first_idx_o` is the fastest index and `res_second_idx_o` is the slowest. With `swap_i`=1 the two are exchanged. `res_bit_o` is 1 only when the result is defined and the first-listed oscillator is the faster one. Otherwise it is 0.
- R9: Cycles with `cnt_valid_i` low are ignored. The value on `cnt_data_i` during those cycles does not enter the search, and the index assignment is unaffected.
- R10: The first count of the next pool may be accepted in the same cycle that the previous result is presented. Each pool's result depends only on its own counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh_i | input | CNT_W | Minimum gap for a defined bit, sampled with the last count |
| swap_i | input | 1 | 0: fastest listed first; 1: slowest listed first; sampled with the last count |
| cnt_valid_i | input | 1 | A count is offered |
| cnt_data_i | input | CNT_W | Frequency count of the next oscillator in index order |
| cnt_ready_o | output | 1 | Counts are accepted |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_bit_o | output | 1 | Response bit |
| res_defined_o | output | 1 | Pair passes the threshold and indices differ |
| res_first_idx_o | output | IDX_W | Index listed first |
| res_second_idx_o | output | IDX_W | Index listed second |
| res_gap_o | output | CNT_W | Highest count minus lowest count |

## Verification
Two events can fall in the same cycle. One is the registered presentation of one pool's result. The other is the acceptance of the first count of the next pool, which reloads the running extremes. The bench provokes this by streaming two pools back to back with no idle cycle between them. The first pool is chosen so that stale extremes would corrupt the second pool's result. The bench then judges the earlier result in the overlapping cycle and the later result one cycle after its own last count, each against its own independent model.

// File: rtl/ro_pick_pkg.sv
package ro_pick_pkg;
  localparam int unsigned MAX_POOL = 16;
  localparam int unsigned MIN_POOL = 2;

  typedef enum logic {
    FAST_FIRST = 1'b0,
    SLOW_FIRST = 1'b1
  } order_e;
endpackage

// File: rtl/ro_pick_seq.sv
module ro_pick_seq #(
  parameter int unsigned POOL_SIZE = 8,
  localparam int unsigned IDX_W = $clog2(POOL_SIZE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             first_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(POOL_SIZE - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     idx_q <= '0;
    else if (acc_i) idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
  end

  assign idx_o   = idx_q;
  assign first_o = (idx_q == '0);
  assign last_o  = (idx_q == LAST_IDX);

  // R2
  idx_in_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);
  // R9
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_i |=> $stable(idx_q));
endmodule

// File: rtl/ro_pick_extremes.sv
module ro_pick_extremes #(
  parameter int unsigned POOL_SIZE = 8,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned IDX_W = $clog2(POOL_SIZE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             first_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] hi_cnt_o,
  output logic [IDX_W-1:0] hi_idx_o,
  output logic [CNT_W-1:0] lo_cnt_o,
  output logic [IDX_W-1:0] lo_idx_o
);
  // strict compares: earlier (lower) index keeps its place on ties
  function automatic logic takes_high(input logic [CNT_W-1:0] cand,
                                      input logic [CNT_W-1:0] held);
    return cand > held;
  endfunction

  function automatic logic takes_low(input logic [CNT_W-1:0] cand,
                                     input logic [CNT_W-1:0] held);
    return cand < held;
  endfunction

  logic [CNT_W-1:0] hi_cnt_q, lo_cnt_q;
  logic [IDX_W-1:0] hi_idx_q, lo_idx_q;
  logic             seen_q;
  logic             hi_win, lo_win;

  assign hi_win = first_i || takes_high(cnt_i, hi_cnt_q);
  assign lo_win = first_i || takes_low(cnt_i, lo_cnt_q);

  always_comb begin
    hi_cnt_o = hi_win ? cnt_i : hi_cnt_q;
    hi_idx_o = hi_win ? idx_i : hi_idx_q;
    lo_cnt_o = lo_win ? cnt_i : lo_cnt_q;
    lo_idx_o = lo_win ? idx_i : lo_idx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
      hi_idx_q <= '0;
      lo_idx_q <= '0;
      seen_q   <= 1'b0;
    end else if (acc_i) begin
      hi_cnt_q <= hi_cnt_o;
      lo_cnt_q <= lo_cnt_o;
      hi_idx_q <= hi_idx_o;
      lo_idx_q <= lo_idx_o;
      seen_q   <= 1'b1;
    end
  end

  // R3 R4
  extremes_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> hi_cnt_q >= lo_cnt_q);
  // R3
  hi_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !first_i) |=> hi_cnt_q >= $past(hi_cnt_q));
  // R4
  lo_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !first_i) |=> lo_cnt_q <= $past(lo_cnt_q));
endmodule

// File: rtl/ro_pick_judge.sv
module ro_pick_judge #(
  parameter int unsigned POOL_SIZE = 8,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned IDX_W = $clog2(POOL_SIZE)
) (
  input  logic [CNT_W-1:0] hi_cnt_i,
  input  logic [IDX_W-1:0] hi_idx_i,
  input  logic [CNT_W-1:0] lo_cnt_i,
  input  logic [IDX_W-1:0] lo_idx_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             swap_i,
  output logic [CNT_W-1:0] gap_o,
  output logic             defined_o,
  output logic             bit_o,
  output logic [IDX_W-1:0] first_idx_o,
  output logic [IDX_W-1:0] second_idx_o
);
  import ro_pick_pkg::*;

  // hi >= lo always, so the plain difference cannot wrap
  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] hi,
                                            input logic [CNT_W-1:0] lo);
    return hi - lo;
  endfunction

  function automatic logic passes(input logic [CNT_W-1:0] gap,
                                  input logic [CNT_W-1:0] thr,
                                  input logic             distinct);
    return distinct && (gap >= thr);
  endfunction

  order_e order;
  logic   distinct;

  assign order     = swap_i ? SLOW_FIRST : FAST_FIRST;
  assign distinct  = (hi_idx_i != lo_idx_i);
  assign gap_o     = span(hi_cnt_i, lo_cnt_i);
  assign defined_o = passes(gap_o, thresh_i, distinct);

  always_comb begin
    if (order == FAST_FIRST) begin
      first_idx_o  = hi_idx_i;
      second_idx_o = lo_idx_i;
      bit_o        = defined_o;
    end else begin
      first_idx_o  = lo_idx_i;
      second_idx_o = hi_idx_i;
      bit_o        = 1'b0;
    end
  end
endmodule

// File: rtl/ro_pool_pick.sv
module ro_pool_pick #(
  parameter int unsigned POOL_SIZE = 8,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned IDX_W = $clog2(POOL_SIZE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             swap_i,
  input  logic             cnt_valid_i,
  input  logic [CNT_W-1:0] cnt_data_i,
  output logic             cnt_ready_o,
  output logic             res_valid_o,
  output logic             res_bit_o,
  output logic             res_defined_o,
  output logic [IDX_W-1:0] res_first_idx_o,
  output logic [IDX_W-1:0] res_second_idx_o,
  output logic [CNT_W-1:0] res_gap_o
);
  import ro_pick_pkg::*;

  initial begin
    if (POOL_SIZE < MIN_POOL || POOL_SIZE > MAX_POOL)
      $error("POOL_SIZE out of range");
  end

  logic             ready_q;
  logic             acc;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_first, cur_last;
  logic             pool_done;
  logic [CNT_W-1:0] hi_cnt, lo_cnt, gap_n;
  logic [IDX_W-1:0] hi_idx, lo_idx, first_n, second_n;
  logic             defined_n, bit_n;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign cnt_ready_o = ready_q;
  assign acc         = cnt_valid_i && ready_q;
  assign pool_done   = acc && cur_last;

  ro_pick_seq #(.POOL_SIZE(POOL_SIZE)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc_i(acc),
    .idx_o(cur_idx), .first_o(cur_first), .last_o(cur_last)
  );

  ro_pick_extremes #(.POOL_SIZE(POOL_SIZE), .CNT_W(CNT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .first_i(cur_first),
    .idx_i(cur_idx), .cnt_i(cnt_data_i),
    .hi_cnt_o(hi_cnt), .hi_idx_o(hi_idx),
    .lo_cnt_o(lo_cnt), .lo_idx_o(lo_idx)
  );

  ro_pick_judge #(.POOL_SIZE(POOL_SIZE), .CNT_W(CNT_W)) u_judge (
    .hi_cnt_i(hi_cnt), .hi_idx_i(hi_idx),
    .lo_cnt_i(lo_cnt), .lo_idx_i(lo_idx),
    .thresh_i(thresh_i), .swap_i(swap_i),
    .gap_o(gap_n), .defined_o(defined_n), .bit_o(bit_n),
    .first_idx_o(first_n), .second_idx_o(second_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o      <= 1'b0;
      res_bit_o        <= 1'b0;
      res_defined_o    <= 1'b0;
      res_first_idx_o  <= '0;
      res_second_idx_o <= '0;
      res_gap_o        <= '0;
    end else begin
      res_valid_o <= pool_done;
      if (pool_done) begin
        res_bit_o        <= bit_n;
        res_defined_o    <= defined_n;
        res_first_idx_o  <= first_n;
        res_second_idx_o <= second_n;
        res_gap_o        <= gap_n;
      end
    end
  end

  // R2
  res_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pool_done |=> res_valid_o);
  // R2
  no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(pool_done));
  // R6
  defined_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_defined_o) |-> res_gap_o >= $past(thresh_i));
  // R6
  rejected_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_defined_o && res_first_idx_o != res_second_idx_o)
      |-> res_gap_o < $past(thresh_i));
  // R7
  same_idx_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_first_idx_o == res_second_idx_o) |-> !res_defined_o);
  // R8
  bit_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> res_bit_o == (res_defined_o && !$past(swap_i)));
endmodule

// File: tb/ro_pool_pick_test.sv
`timescale 1ns/1ps
module ro_pool_pick_test;
  localparam int K = 8;
  localparam int W = 16;
  typedef logic [W-1:0] pool_t [K];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] thresh = '0;
  logic swap = 1'b0;
  logic cnt_valid = 1'b0;
  logic [W-1:0] cnt_data = '0;
  logic cnt_ready, res_valid, res_bit, res_defined;
  logic [2:0] res_first, res_second;
  logic [W-1:0] res_gap;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ro_pool_pick #(.POOL_SIZE(K), .CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .thresh_i(thresh), .swap_i(swap),
    .cnt_valid_i(cnt_valid), .cnt_data_i(cnt_data), .cnt_ready_o(cnt_ready),
    .res_valid_o(res_valid), .res_bit_o(res_bit), .res_defined_o(res_defined),
    .res_first_idx_o(res_first), .res_second_idx_o(res_second),
    .res_gap_o(res_gap)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] d);
    @(negedge clk);
    cnt_valid = 1'b1;
    cnt_data  = d;
  endtask

  task automatic idle(input logic [W-1:0] junk);
    @(negedge clk);
    cnt_valid = 1'b0;
    cnt_data  = junk;
  endtask

  // drive a pool; bubble bit i puts an idle cycle with junk before count i
  task automatic feed(input pool_t c, input logic [K-1:0] bubbles);
    for (int i = 0; i < K; i++) begin
      if (bubbles[i]) idle(16'hFFFF);
      drive(c[i]);
    end
  endtask

  // independent model: find extreme values first, then first index holding each
  task automatic check_result(input string tag, input pool_t c,
                              input logic [W-1:0] thr, input logic sw);
    int vmax, vmin, imax, imin, gap, fi, si, def, b;
    vmax = 0; vmin = 65535;
    for (int i = 0; i < K; i++) begin
      if (int'(c[i]) > vmax) vmax = int'(c[i]);
      if (int'(c[i]) < vmin) vmin = int'(c[i]);
    end
    imax = -1; imin = -1;
    for (int i = K - 1; i >= 0; i--) begin
      if (int'(c[i]) == vmax) imax = i;
      if (int'(c[i]) == vmin) imin = i;
    end
    gap = vmax - vmin;
    def = (imax != imin && gap >= int'(thr)) ? 1 : 0;
    fi  = sw ? imin : imax;
    si  = sw ? imax : imin;
    b   = (def == 1 && !sw) ? 1 : 0;
    chk("R2", {tag, " valid"}, int'(res_valid), 1);
    chk("R3", {tag, " fastest idx"}, int'(sw ? res_second : res_first), imax);
    chk("R4", {tag, " slowest idx"}, int'(sw ? res_first : res_second), imin);
    chk("R8", {tag, " first idx"}, int'(res_first), fi);
    chk("R8", {tag, " second idx"}, int'(res_second), si);
    chk("R5", {tag, " gap"}, int'(res_gap), gap);
    chk(imax == imin ? "R7" : "R6", {tag, " defined"}, int'(res_defined), def);
    chk("R8", {tag, " bit"}, int'(res_bit), b);
  endtask

  task automatic run_pool(input string tag, input pool_t c, input logic [W-1:0] thr,
                          input logic sw, input logic [K-1:0] bubbles);
    thresh = thr;
    swap = sw;
    feed(c, bubbles);
    @(negedge clk);
    cnt_valid = 1'b0;
    check_result(tag, c, thr, sw);
    @(negedge clk);
    chk("R2", {tag, " strobe one cycle"}, int'(res_valid), 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(cnt_ready), 0);
    chk("R1", "valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(cnt_ready), 1);
    chk("R1", "valid after reset", int'(res_valid), 0);
  endtask

  task automatic test_distinct();
    pool_t c = '{16'd500, 16'd620, 16'd410, 16'd590, 16'd700, 16'd455, 16'd300, 16'd512};
    run_pool("R3 R4 distinct", c, 16'd100, 1'b0, '0);
  endtask

  task automatic test_ties();
    pool_t c = '{16'd200, 16'd900, 16'd100, 16'd900, 16'd100, 16'd500, 16'd900, 16'd100};
    run_pool("R3 R4 ties", c, 16'd10, 1'b0, '0);
  endtask

  task automatic test_threshold_edge();
    pool_t c = '{16'd1000, 16'd1040, 16'd1010, 16'd1020, 16'd1005, 16'd1030, 16'd1015, 16'd1025};
    run_pool("R6 gap equals thr", c, 16'd40, 1'b0, '0);
    run_pool("R6 gap below thr", c, 16'd41, 1'b0, '0);
  endtask

  task automatic test_all_equal();
    pool_t c = '{default: 16'd777};
    run_pool("R7 equal thr0", c, 16'd0, 1'b0, '0);
    run_pool("R7 equal swap", c, 16'd0, 1'b1, '0);
  endtask

  task automatic test_full_range();
    pool_t c = '{16'd5, 16'd9, 16'hFFFF, 16'd0, 16'd1234, 16'd8, 16'd7, 16'd6};
    run_pool("R5 full range", c, 16'hFFFF, 1'b0, '0);
  endtask

  task automatic test_swap();
    pool_t c = '{16'd300, 16'd100, 16'd250, 16'd800, 16'd50, 16'd400, 16'd600, 16'd200};
    run_pool("R8 swap", c, 16'd20, 1'b1, '0);
    run_pool("R8 swap undefined", c, 16'd2000, 1'b1, '0);
  endtask

  task automatic test_bubbles();
    pool_t c = '{16'd400, 16'd410, 16'd420, 16'd380, 16'd390, 16'd405, 16'd415, 16'd395};
    run_pool("R9 bubbles", c, 16'd5, 1'b0, 8'b1010_0110);
  endtask

  task automatic test_back_to_back();
    pool_t a = '{16'd9000, 16'd10, 16'd20, 16'd30, 16'd40, 16'd50, 16'd60, 16'd70};
    pool_t b = '{16'd300, 16'd310, 16'd320, 16'd330, 16'd340, 16'd350, 16'd360, 16'd290};
    thresh = 16'd15;
    swap = 1'b0;
    feed(a, '0);
    drive(b[0]);
    check_result("R10 first pool", a, 16'd15, 1'b0);
    for (int i = 1; i < K; i++) begin
      drive(b[i]);
      chk("R10", "no strobe mid pool", int'(res_valid), 0);
    end
    @(negedge clk);
    cnt_valid = 1'b0;
    check_result("R10 second pool", b, 16'd15, 1'b0);
  endtask

  initial begin
    test_reset();
    test_distinct();
    test_ties();
    test_threshold_edge();
    test_all_equal();
    test_full_range();
    test_swap();
    test_bubbles();
    test_back_to_back();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule